// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block raises a periodic interrupt at a fixed cadence measured in bus cycles. The period is a base count (8192 cycles by default) multiplied by one, two, four or eight, chosen by a two-bit rate field. When a period completes, a sticky flag is set. The interrupt request output is high while that flag and its enable bit are both set. The block keeps its own elapsed-cycle counter and does not share any main timer counter.

Software uses a small byte register interface. The rate field sits in a control byte, the flag in a status byte, and the enable in a mask byte. The counter runs from the moment of the last expiry. A rewrite of the rate therefore moves the next expiry to that anchor plus the new period, and does not restart the count. If that new expiry time has already passed, the flag is raised on the following cycle and the count restarts from that point.

Top module: `rti_gen`

## Requirements
- R1: The period in bus cycles equals BASE_CYCLES × 2^rate. The rate field is bits 1:0 of the control byte, at address 0. After reset the first expiry sets the flag at the end of the BASE_CYCLES-th clock edge after reset is released, and each later expiry comes one full period after the previous one.
- R2: On each expiry the periodic flag is set. The flag is bit 6 of the status byte, at address 1.
- R3: Writing the status byte with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged. If an expiry happens in the same cycle as a clear, the set wins.
- R4: A write to the rate field does not set the flag by itself. The next expiry comes at the previous expiry plus the new period.
- R5: If a rate write makes that expiry time already past, the flag is set on the next cycle and the next period counts from that cycle.
- R6: The interrupt request equals the flag AND the enable. The enable is bit 6 of the mask byte, at address 2.
- R7: Reset clears the pending count, the flag, the enable and the rate field. Unused bits of all three bytes read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 status, 2 mask |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things: an expiry always sets the flag, the flag changes only on an expiry or a write-one clear, the request stays low while the mask is off, and the elapsed counter restarts at each expiry and never reaches the longest period. The bench scenarios cover the timing: the exact cycle of each expiry, the phase kept across rate rewrites in both directions (including the case where the expiry is already past), and that a flag set while masked is still readable.

// File: rtl/rti_gen.sv
module rti_gen #(
  parameter int BASE_CYCLES = 8192,
  parameter int RATE_W      = 2,
  parameter int FLAG_BIT    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int MAX_PERIOD = BASE_CYCLES << ((1 << RATE_W) - 1);
  localparam int CW = $clog2(MAX_PERIOD) + 1;
  localparam logic [CW-1:0] BASE_W = CW'(BASE_CYCLES);

  logic [RATE_W-1:0] rate_q;
  logic [CW-1:0]     elapsed;
  logic              flag_q;
  logic              en_q;
  logic [CW-1:0]     period;
  logic              hit;
  logic              clr;

  assign period = BASE_W << rate_q;
  assign hit    = elapsed >= period - CW'(1);
  assign clr    = wr_en && addr == 2'd1 && wdata[FLAG_BIT];
  assign irq    = flag_q & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      rate_q  <= '0;
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      elapsed <= hit ? '0 : elapsed + CW'(1);
      if (hit)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (wr_en && addr == 2'd0) rate_q <= wdata[RATE_W-1:0];
      if (wr_en && addr == 2'd2) en_q   <= wdata[FLAG_BIT];
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      2'd0:    rdata[RATE_W-1:0] = rate_q;
      2'd1:    rdata[FLAG_BIT]   = flag_q;
      2'd2:    rdata[FLAG_BIT]   = en_q;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rti_gen_chk.sv
module rti_gen_chk #(
  parameter int CW = 8,
  parameter int MAX_PERIOD = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          hit,
  input logic          clr,
  input logic          flag_q,
  input logic          en_q,
  input logic          irq,
  input logic [CW-1:0] elapsed
);
  assert_set_on_expiry_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag_q);
  assert_flag_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr) |=> $stable(flag_q));
  assert_clear_works_R3: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag_q);
  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq);
  assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
    hit |=> elapsed == '0);
  assert_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    elapsed < CW'(MAX_PERIOD));
endmodule

bind rti_gen rti_gen_chk #(.CW(CW), .MAX_PERIOD(MAX_PERIOD)) u_chk (
  .clk(clk), .rst(rst), .hit(hit), .clr(clr), .flag_q(flag_q),
  .en_q(en_q), .irq(irq), .elapsed(elapsed)
);

// File: tb/rti_gen_test.sv
module rti_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int expq[$];
  logic irq_d = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  rti_gen #(.BASE_CYCLES(32)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // Monitor: pop an expected edge number on every rising request.
  always @(negedge clk) begin
    if (rst) irq_d = 1'b0;
    else begin
      if (irq && !irq_d) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected request at edge %0d, expected none", cyc);
        end else begin
          int e;
          e = expq.pop_front();
          if (e != cyc) begin
            fails++;
            $display("FAIL R1/R4/R5 request at edge %0d, expected %0d", cyc, e);
          end
        end
      end
      irq_d = irq;
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr_at(input int edge_n, input logic [1:0] a, input logic [7:0] d);
    wait_cyc(edge_n - 1);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d read %h, expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq %b, expected %b", tag, irq, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_chk(2'd0, 8'h00, "R7 reset ctrl");
    rd_chk(2'd1, 8'h00, "R7 reset status");
    rd_chk(2'd2, 8'h00, "R7 reset mask");
    irq_chk(1'b0, "R7 reset irq");
    expq.push_back(32);  expq.push_back(64);  expq.push_back(96);
    expq.push_back(160); expq.push_back(416); expq.push_back(461);
    expq.push_back(493);
    rst = 1'b0;
    wr_at(2, 2'd2, 8'h40);
    rd_chk(2'd2, 8'h40, "R6 mask set");
    rd_chk(2'd3, 8'h00, "R7 unused address");
    wr_at(34, 2'd1, 8'h40);
    rd_chk(2'd1, 8'h00, "R3 clear by one");
    wr_at(70, 2'd1, 8'hBF);
    rd_chk(2'd1, 8'h40, "R3 write zero ignored");
    irq_chk(1'b1, "R6 irq with flag and enable");
    wr_at(72, 2'd1, 8'h40);
    wr_at(98, 2'd1, 8'h40);
    wr_at(100, 2'd0, 8'h01);
    rd_chk(2'd1, 8'h00, "R4 rate write sets no flag");
    rd_chk(2'd0, 8'h01, "R1 rate readback");
    wr_at(162, 2'd1, 8'h40);
    wr_at(170, 2'd0, 8'hFF);
    rd_chk(2'd0, 8'h03, "R7 unused ctrl bits read zero");
    wr_at(418, 2'd1, 8'h40);
    wr_at(460, 2'd0, 8'h00);
    wr_at(463, 2'd1, 8'h40);
    wr_at(495, 2'd1, 8'h40);
    wr_at(500, 2'd2, 8'h00);
    wait_cyc(526);
    rd_chk(2'd1, 8'h40, "R2 flag set while masked");
    irq_chk(1'b0, "R6 masked irq low");
    checks++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expected events %0d, expected 0", expq.size());
    end
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_chk(2'd0, 8'h00, "R7 mid reset ctrl");
    rd_chk(2'd1, 8'h00, "R7 mid reset flag");
    rd_chk(2'd2, 8'h00, "R7 mid reset mask");
    irq_chk(1'b0, "R7 mid reset irq");
    rst = 1'b0;
    wait_cyc(20);
    rd_chk(2'd1, 8'h00, "R7 count restarted after reset");
    finish_run();
  end
endmodule